// File: doc/BRIEF.md
# Processor Clock, Ready and Reset Conditioner

This block runs from one fast reference clock and derives every timing signal that a processor core and its slow peripherals need. It divides the reference by three to make the processor clock, which is high for one reference period and low for two. It then halves that clock again to make a square peripheral clock. With a 15 MHz reference, the processor clock runs at 5 MHz and the peripheral clock at 2.5 MHz.

Two asynchronous requests enter the block. One is a ready request from slow memory or I/O. The other is a reset request from a power-on or push-button source. Each request passes through a short flop chain clocked by the reference. The block then changes its ready and reset outputs only on falling edges of the derived processor clock. The processor samples these outputs on its rising edge, so it always sees a settled level.

A synchronous clear input forces the divider into a fixed phase. This makes the start of operation deterministic.

Top module: `tri_clock_conditioner`

## Requirements
- R1: `cpu_clk` has a period of DIV reference cycles (default 3). Over any span of DIV×k cycles it is high in exactly k of them.
- R2: `cpu_clk` is high for exactly one reference cycle and low for the other DIV−1 cycles of each period.
- R3: `per_clk` changes level on every falling edge of `cpu_clk` and at no other time. Its period is therefore 2×DIV reference cycles and its duty cycle is 50%.
- R4: A new level on `rdy_req` appears on `cpu_ready` no earlier than 2 and no later than DIV+1 reference edges after the level is applied. A level is held only if it is stable for at least that long.
- R5: `cpu_ready` changes only on a reference edge at which `cpu_clk` falls.
- R6: `cpu_reset` goes high on the second reference edge after `rst_req` is applied high, at any divider phase. The first edge alone does not raise it.
- R7: After `rst_req` returns low, `cpu_reset` falls no earlier than 3 and no later than DIV+2 reference edges later. It falls only on an edge at which `cpu_clk` falls.
- R8: While `div_clear` is high, the outputs are held as follows: `cpu_clk` = 1, `per_clk` = 0, `cpu_ready` = 0 and `cpu_reset` = 1. After `div_clear` is released, `cpu_clk` falls on the first reference edge and rises again DIV edges after the release. `per_clk` first rises on that same first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock, DIV times the processor rate |
| div_clear | input | 1 | Synchronous clear of the divider phase and synchronizers, active high |
| rdy_req | input | 1 | Asynchronous ready request from slow memory or I/O, active high |
| rst_req | input | 1 | Asynchronous reset request, active high |
| cpu_clk | output | 1 | Processor clock, one-third duty cycle by default |
| per_clk | output | 1 | Peripheral clock at half the processor clock rate |
| cpu_ready | output | 1 | Synchronized ready, updated on processor clock falling edges |
| cpu_reset | output | 1 | Synchronized reset, released on a processor clock falling edge |

## Verification
The assertions check the following on every reference cycle:
- the one-high, DIV−1-low shape and exact period of `cpu_clk`;
- that `per_clk`, `cpu_ready` and a falling `cpu_reset` move only together with a `cpu_clk` fall;
- the two-edge latency from a reset request to `cpu_reset`;
- the forced output levels under clear.

Some properties can only be shown by the bench's scenarios:
- the exact phase reached after a clear at different points of the cycle;
- the bounded windows in which a new ready or reset level reaches the outputs;
- that a rising ready is held at its final level.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  // Next divider phase: counts 0 .. div-1 and wraps.
  function automatic int phase_after(input int ph, input int div);
    return (ph >= div - 1) ? 0 : ph + 1;
  endfunction

  // Reset output next state: set from the first synchronizer stage,
  // released only at a processor-clock fall once both stages read low.
  function automatic logic reset_next(input logic cur, input logic first_stage,
                                      input logic last_stage, input logic fall);
    if (first_stage)
      return 1'b1;
    if (fall && !last_stage)
      return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/tcc_sync_chain.sv
module tcc_sync_chain #(
  parameter int STAGES = 2,
  parameter bit INIT   = 1'b0
) (
  input  logic              clk,
  input  logic              clear,
  input  logic              d,
  output logic [STAGES-1:0] taps
);
  logic [STAGES-1:0] st_q;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk) begin
      if (clear) st_q <= INIT;
      else       st_q <= d;
    end
  end else begin : g_shift
    always_ff @(posedge clk) begin
      if (clear) st_q <= {STAGES{INIT}};
      else       st_q <= {st_q[STAGES-2:0], d};
    end
  end

  assign taps = st_q;
endmodule

// File: rtl/tcc_phase_div.sv
module tcc_phase_div #(
  parameter int DIV = 3
) (
  input  logic ref_clk,
  input  logic clear,
  output logic clk_out,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] ph_q;
  logic          clk_q;

  always_ff @(posedge ref_clk) begin
    if (clear) begin
      ph_q  <= '0;
      clk_q <= 1'b1;
    end else begin
      ph_q  <= PW'(tcc_pkg::phase_after(int'(ph_q), DIV));
      clk_q <= (ph_q == LAST);
    end
  end

  // Edge events: the output clock rises / falls at the coming reference edge.
  assign rise_evt = (ph_q == LAST);
  assign fall_evt = (ph_q == '0);
  assign clk_out  = clk_q;
endmodule

// File: rtl/tcc_ready_cond.sv
module tcc_ready_cond #(
  parameter int STAGES = 2
) (
  input  logic ref_clk,
  input  logic clear,
  input  logic fall_evt,
  input  logic req,
  output logic ready
);
  localparam int FREE = STAGES - 1;

  logic [FREE-1:0] pre;
  logic            ready_q;

  tcc_sync_chain #(.STAGES(FREE), .INIT(1'b0)) u_chain (
    .clk   (ref_clk),
    .clear (clear),
    .d     (req),
    .taps  (pre)
  );

  // Final stage loads only when the processor clock falls.
  always_ff @(posedge ref_clk) begin
    if (clear)         ready_q <= 1'b0;
    else if (fall_evt) ready_q <= pre[FREE-1];
  end

  assign ready = ready_q;
endmodule

// File: rtl/tcc_reset_cond.sv
module tcc_reset_cond #(
  parameter int STAGES = 2
) (
  input  logic ref_clk,
  input  logic clear,
  input  logic fall_evt,
  input  logic req,
  output logic reset
);
  logic [STAGES-1:0] st;
  logic              reset_q;

  tcc_sync_chain #(.STAGES(STAGES), .INIT(1'b1)) u_chain (
    .clk   (ref_clk),
    .clear (clear),
    .d     (req),
    .taps  (st)
  );

  always_ff @(posedge ref_clk) begin
    if (clear) reset_q <= 1'b1;
    else       reset_q <= tcc_pkg::reset_next(reset_q, st[0], st[STAGES-1], fall_evt);
  end

  assign reset = reset_q;
endmodule

// File: rtl/tri_clock_conditioner.sv
module tri_clock_conditioner #(
  parameter int DIV        = 3,
  parameter int RDY_STAGES = 2,
  parameter int RST_STAGES = 2
) (
  input  logic ref_clk,
  input  logic div_clear,
  input  logic rdy_req,
  input  logic rst_req,
  output logic cpu_clk,
  output logic per_clk,
  output logic cpu_ready,
  output logic cpu_reset
);
  logic rise_evt;
  logic fall_evt;
  logic per_q;

  tcc_phase_div #(.DIV(DIV)) u_div (
    .ref_clk  (ref_clk),
    .clear    (div_clear),
    .clk_out  (cpu_clk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  // Peripheral clock: toggles at each processor clock fall.
  always_ff @(posedge ref_clk) begin
    if (div_clear)     per_q <= 1'b0;
    else if (fall_evt) per_q <= ~per_q;
  end
  assign per_clk = per_q;

  tcc_ready_cond #(.STAGES(RDY_STAGES)) u_rdy (
    .ref_clk  (ref_clk),
    .clear    (div_clear),
    .fall_evt (fall_evt),
    .req      (rdy_req),
    .ready    (cpu_ready)
  );

  tcc_reset_cond #(.STAGES(RST_STAGES)) u_rst (
    .ref_clk  (ref_clk),
    .clear    (div_clear),
    .fall_evt (fall_evt),
    .req      (rst_req),
    .reset    (cpu_reset)
  );
endmodule

// File: rtl/tcc_checker.sv
module tcc_checker #(
  parameter int DIV = 3
) (
  input logic ref_clk,
  input logic div_clear,
  input logic rst_req,
  input logic cpu_clk,
  input logic per_clk,
  input logic cpu_ready,
  input logic cpu_reset,
  input logic rise_evt,
  input logic fall_evt
);
  logic        clr_d   = 1'b0;
  logic        valid_q = 1'b0;
  logic [15:0] since_q = '0;

  always_ff @(posedge ref_clk) begin
    clr_d <= div_clear;
    if (div_clear) begin
      valid_q <= 1'b0;
      since_q <= '0;
    end else if (rise_evt) begin
      valid_q <= 1'b1;
      since_q <= '0;
    end else if (since_q != 16'hFFFF) begin
      since_q <= since_q + 16'd1;
    end
  end

  AST_RISE_PERIOD: assert property (@(posedge ref_clk) disable iff (div_clear || clr_d)
    (rise_evt && valid_q) |-> (since_q == 16'(DIV - 1))); // R1

  AST_HIGH_ONE_CYCLE: assert property (@(posedge ref_clk) disable iff (div_clear || clr_d)
    $rose(cpu_clk) |=> !cpu_clk); // R2

  AST_FALL_EVENT: assert property (@(posedge ref_clk) disable iff (div_clear || clr_d)
    fall_evt |=> $fell(cpu_clk)); // R2

  AST_PER_ON_FALL: assert property (@(posedge ref_clk) disable iff (div_clear || clr_d)
    !$stable(per_clk) |-> $fell(cpu_clk)); // R3

  AST_READY_ON_FALL: assert property (@(posedge ref_clk) disable iff (div_clear || clr_d)
    !$stable(cpu_ready) |-> $fell(cpu_clk)); // R5

  AST_RESET_RAISE: assert property (@(posedge ref_clk) disable iff (div_clear || clr_d)
    rst_req |-> ##2 cpu_reset); // R6

  AST_RESET_RELEASE: assert property (@(posedge ref_clk) disable iff (div_clear || clr_d)
    $fell(cpu_reset) |-> $fell(cpu_clk)); // R7

  AST_CLEAR_STATE: assert property (@(posedge ref_clk)
    clr_d |-> (cpu_clk && !per_clk && !cpu_ready && cpu_reset)); // R8
endmodule

bind tri_clock_conditioner tcc_checker #(.DIV(DIV)) u_chk (
  .ref_clk   (ref_clk),
  .div_clear (div_clear),
  .rst_req   (rst_req),
  .cpu_clk   (cpu_clk),
  .per_clk   (per_clk),
  .cpu_ready (cpu_ready),
  .cpu_reset (cpu_reset),
  .rise_evt  (rise_evt),
  .fall_evt  (fall_evt)
);

// File: tb/sim_tri_clock_conditioner.sv
module sim_tri_clock_conditioner;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 3;

  logic ref_clk   = 1'b0;
  logic div_clear = 1'b1;
  logic rdy_req   = 1'b0;
  logic rst_req   = 1'b0;
  logic cpu_clk, per_clk, cpu_ready, cpu_reset;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  tri_clock_conditioner #(.DIV(DIV)) u0 (
    .ref_clk   (ref_clk),
    .div_clear (div_clear),
    .rdy_req   (rdy_req),
    .rst_req   (rst_req),
    .cpu_clk   (cpu_clk),
    .per_clk   (per_clk),
    .cpu_ready (cpu_ready),
    .cpu_reset (cpu_reset)
  );

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge ref_clk);
    @(negedge ref_clk);
  endtask

  // Outputs while clear is held (R8).
  task automatic check_clear_levels();
    chk(cpu_clk == 1'b1,   "R8 cpu_clk under clear",   int'(cpu_clk),   1);
    chk(per_clk == 1'b0,   "R8 per_clk under clear",   int'(per_clk),   0);
    chk(cpu_ready == 1'b0, "R8 cpu_ready under clear", int'(cpu_ready), 0);
    chk(cpu_reset == 1'b1, "R8 cpu_reset under clear", int'(cpu_reset), 1);
  endtask

  // Release clear and follow the clock pattern for n samples.
  // k counts reference edges since release; cpu_clk high when k%DIV==0,
  // per_clk has toggled once for each edge k' <= k with k'%DIV==1.
  task automatic release_and_follow(input int n);
    int highs = 0;
    div_clear = 1'b0;
    for (int k = 0; k < n; k++) begin
      int exp_clk = (k % DIV == 0) ? 1 : 0;
      int exp_per = ((k + DIV - 1) / DIV) % 2;
      if (k <= DIV)
        chk(int'(cpu_clk) == exp_clk, "R8 phase after clear", int'(cpu_clk), exp_clk);
      else
        chk(int'(cpu_clk) == exp_clk, "R2 cpu_clk shape", int'(cpu_clk), exp_clk);
      chk(int'(per_clk) == exp_per, "R3 per_clk level", int'(per_clk), exp_per);
      if (cpu_clk) highs++;
      step();
    end
    chk(highs == (n + DIV - 1) / DIV, "R1 high count", highs, (n + DIV - 1) / DIV);
  endtask

  task automatic t_reset_state();
    step(); step(); step();
    check_clear_levels();
  endtask

  task automatic t_clock_shape();
    release_and_follow(36);
  endtask

  task automatic t_reset_cond();
    logic prev_clk;
    int   n = 0;
    bit   fell_ok = 1'b0;
    chk(cpu_reset == 1'b0, "R7 released after clear", int'(cpu_reset), 0);
    rst_req = 1'b1;
    step();
    chk(cpu_reset == 1'b0, "R6 not after one edge", int'(cpu_reset), 0);
    step();
    chk(cpu_reset == 1'b1, "R6 high after two edges", int'(cpu_reset), 1);
    step(); step(); step();
    rst_req = 1'b0;
    for (int i = 1; i <= 10; i++) begin
      prev_clk = cpu_clk;
      step();
      if (n == 0 && cpu_reset == 1'b0) begin
        n = i;
        fell_ok = (prev_clk == 1'b1) && (cpu_clk == 1'b0);
      end
    end
    chk(n >= 3 && n <= DIV + 2, "R7 release latency", n, DIV + 2);
    chk(fell_ok, "R7 release on cpu_clk fall", int'(fell_ok), 1);
  endtask

  // Apply a ready level and measure when it arrives (R4, R5).
  task automatic ready_level(input logic lvl);
    logic prev_clk, prev_rdy;
    int   n = 0;
    bit   align_ok = 1'b1;
    rdy_req = lvl;
    for (int i = 1; i <= 8; i++) begin
      prev_clk = cpu_clk;
      prev_rdy = cpu_ready;
      step();
      if (cpu_ready != prev_rdy && !(prev_clk == 1'b1 && cpu_clk == 1'b0))
        align_ok = 1'b0;
      if (n == 0 && cpu_ready == lvl) n = i;
    end
    chk(n >= 2 && n <= DIV + 1, "R4 ready latency", n, DIV + 1);
    chk(align_ok, "R5 ready changes on cpu_clk fall", int'(align_ok), 1);
    chk(cpu_ready == lvl, "R4 ready holds level", int'(cpu_ready), int'(lvl));
  endtask

  task automatic t_ready();
    ready_level(1'b1);
    ready_level(1'b0);
    step();
    ready_level(1'b1);
    step(); step();
    ready_level(1'b0);
  endtask

  task automatic t_clear_realign();
    ready_level(1'b1);
    for (int off = 0; off < DIV; off++) begin
      for (int j = 0; j < off + 1; j++) step();
      div_clear = 1'b1;
      step();
      check_clear_levels();
      release_and_follow(2 * DIV + 1);
    end
    rdy_req = 1'b0;
  endtask

  initial begin
    t_reset_state();
    t_clock_shape();
    t_reset_cond();
    t_ready();
    t_clear_realign();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule